// File: doc/BRIEF.md
# ADC Code-Transition Calibration Monitor

This block watches the output code stream of a free-running sampling converter during manual offset and gain trimming. It measures how close the analog input sits to one chosen boundary between two adjacent output codes. For the zero-end boundary it watches the codes 0x000 and 0x001. For the full-scale boundary it watches 0xFFE and 0xFFF. The boundary is reached when the input spends equal time on each side of it, which means the two codes appear equally often.

Each measurement window contains a programmable number of valid samples. During the window the block counts hits on the lower target code, hits on the upper target code, and all other codes. At the end of the window it latches both hit counts. It also latches a balanced verdict and an out-of-band flag, and it pulses a done strobe. The operator or a controller adjusts the trim, reads the next window, and repeats.

Trimming must follow a set order: the zero end first, then full scale. The block enforces this order. A request for a full-scale window is refused, and that window runs at the zero end, until a zero-end window has ended balanced.

Top module: `adc_xition_monitor`

## Requirements
- R1: In offset mode the lower target code is 0x000 and the upper target code is 0x001. In gain mode the lower is 0xFFE and the upper is 0xFFF (for a 12-bit code). `lo_count_o` reports the lower-code hits and `hi_count_o` reports the upper-code hits.
- R2: A window ends on its `win_len_i`-th valid sample, and that sample is included in the window. The counters then start from zero for the next window. A window length of 0 is treated as 1.
- R3: `done_o` is high for one cycle, in the cycle after the clock edge that accepted the last sample of a window. The result outputs change only together with `done_o` and hold their values between pulses.
- R4: `balanced_o` is 1 when both hit counts are nonzero and their absolute difference is at most `tol_i`.
- R5: `out_of_band_o` is 1 when the number of samples matching neither target code is greater than half the window length (rounded down).
- R6: A window requested with `gain_req_i`=1 runs in gain mode only if `offset_cleared_o` is 1 at the window's first sample. Otherwise it runs in offset mode and reports `gain_refused_o`=1 and `gain_mode_o`=0.
- R7: `offset_cleared_o` becomes 1 when an offset-mode window ends balanced. It becomes 0 when an offset-mode window ends unbalanced. Gain-mode windows leave it unchanged.
- R8: The mode request and the window length are sampled at the first sample of each window. Changes to them during the window take effect only at the next window.
- R9: After reset, every output is 0.
- R10: A cycle with `smp_valid_i`=0 is ignored, whatever code is on `smp_code_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | A converter code is present this cycle |
| smp_code_i | input | CODE_W | Converter output code, straight binary |
| gain_req_i | input | 1 | 1 requests the full-scale boundary, 0 the zero boundary |
| win_len_i | input | WIN_W | Number of valid samples per window |
| tol_i | input | WIN_W | Allowed difference between the two hit counts |
| lo_count_o | output | WIN_W | Lower-code hits in the last window |
| hi_count_o | output | WIN_W | Upper-code hits in the last window |
| balanced_o | output | 1 | Last window judged balanced |
| out_of_band_o | output | 1 | Last window had mostly other codes |
| gain_mode_o | output | 1 | Last window ran at the full-scale boundary |
| gain_refused_o | output | 1 | Last window requested gain but ran offset |
| offset_cleared_o | output | 1 | The zero end has been trimmed balanced |
| done_o | output | 1 | One-cycle pulse: results updated |

## Verification
The stimulus patterns are interleaved mixes of the four target codes and a mid-scale code, with idle cycles carrying a target code placed between samples. This separates correct code classification from counting of invalid cycles.

Pairs of windows that differ only in tolerance, or only by one stray sample, place the balanced and out-of-band thresholds exactly on their boundaries. Full-scale requests are sent before the zero end is trimmed and again after it is lost, so a refused window and a granted one can be told apart by counts as well as by flags. In every window the driver flips the mode request and the length after the first sample, which exposes any decision not held for the whole window. A 1024-sample window and a zero-length window cover the two ends of the length range.

// File: rtl/calmon_pkg.sv
package calmon_pkg;

  typedef enum logic {
    MODE_OFFSET = 1'b0,
    MODE_GAIN   = 1'b1
  } cal_mode_e;

  // lower code of the watched boundary for a given mode
  function automatic logic [31:0] low_target(input logic gain, input int unsigned code_w);
    logic [31:0] full;
    full = (32'd1 << code_w) - 32'd1;
    return gain ? (full - 32'd1) : 32'd0;
  endfunction

  function automatic logic [31:0] abs_diff(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic pair_balanced(input logic [31:0] lo, input logic [31:0] hi,
                                         input logic [31:0] tol);
    return (lo != 32'd0) && (hi != 32'd0) && (abs_diff(lo, hi) <= tol);
  endfunction

  function automatic logic over_half(input logic [31:0] others, input logic [31:0] len);
    return others > (len >> 1);
  endfunction

endpackage

// File: rtl/calmon_classify.sv
module calmon_classify #(
  parameter int CODE_W = 12
) (
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              gain_i,
  output logic              hit_lo_o,
  output logic              hit_hi_o,
  output logic              hit_other_o
);
  localparam logic [CODE_W-1:0] OFS_LO = '0;
  localparam logic [CODE_W-1:0] GAIN_LO =
    CODE_W'(calmon_pkg::low_target(1'b1, CODE_W));

  logic [CODE_W-1:0] lo_code;
  logic [CODE_W-1:0] hi_code;

  always_comb begin
    lo_code     = gain_i ? GAIN_LO : OFS_LO;
    hi_code     = lo_code + CODE_W'(1);
    hit_lo_o    = valid_i && (code_i == lo_code);
    hit_hi_o    = valid_i && (code_i == hi_code);
    hit_other_o = valid_i && !hit_lo_o && !hit_hi_o;
  end
endmodule

// File: rtl/calmon_window.sv
module calmon_window #(
  parameter int WIN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             gain_req_i,
  input  logic             gain_allowed_i,
  input  logic [WIN_W-1:0] len_req_i,
  output logic             first_o,
  output logic             last_o,
  output logic             gain_eff_o,
  output logic             refused_o,
  output logic [WIN_W-1:0] len_eff_o,
  output logic             mid_o,
  output logic [WIN_W-1:0] idx_o,
  output logic [WIN_W-1:0] len_held_o
);
  logic             mid_q;
  logic [WIN_W-1:0] idx_q;
  logic [WIN_W-1:0] len_q;
  logic             gain_q;
  logic             ref_q;
  logic [WIN_W-1:0] idx_cur;
  logic [WIN_W-1:0] len_clamped;

  always_comb begin
    len_clamped = (len_req_i == '0) ? WIN_W'(1) : len_req_i;
    first_o     = !mid_q;
    len_eff_o   = first_o ? len_clamped : len_q;
    gain_eff_o  = first_o ? (gain_req_i && gain_allowed_i) : gain_q;
    refused_o   = first_o ? (gain_req_i && !gain_allowed_i) : ref_q;
    idx_cur     = first_o ? '0 : idx_q;
    last_o      = valid_i && (idx_cur == (len_eff_o - WIN_W'(1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q  <= 1'b0;
      idx_q  <= '0;
      len_q  <= WIN_W'(1);
      gain_q <= 1'b0;
      ref_q  <= 1'b0;
    end else if (valid_i) begin
      if (first_o) begin
        len_q  <= len_clamped;
        gain_q <= gain_eff_o;
        ref_q  <= refused_o;
      end
      if (last_o) begin
        mid_q <= 1'b0;
        idx_q <= '0;
      end else begin
        mid_q <= 1'b1;
        idx_q <= idx_cur + WIN_W'(1);
      end
    end
  end

  assign mid_o      = mid_q;
  assign idx_o      = idx_q;
  assign len_held_o = len_q;
endmodule

// File: rtl/calmon_counter.sv
module calmon_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         restart_i,
  input  logic         inc_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] cnt_q;

  assign next_o = (restart_i ? '0 : cnt_q) + W'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= next_o;
  end
endmodule

// File: rtl/calmon_judge.sv
module calmon_judge #(
  parameter int WIN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [WIN_W-1:0] lo_i,
  input  logic [WIN_W-1:0] hi_i,
  input  logic [WIN_W-1:0] other_i,
  input  logic [WIN_W-1:0] len_i,
  input  logic [WIN_W-1:0] tol_i,
  input  logic             gain_i,
  input  logic             refused_i,
  output logic [WIN_W-1:0] lo_o,
  output logic [WIN_W-1:0] hi_o,
  output logic             balanced_o,
  output logic             oob_o,
  output logic             gain_o,
  output logic             refused_o,
  output logic             cleared_o,
  output logic             done_o
);
  logic bal_now;
  logic oob_now;

  always_comb begin
    bal_now = calmon_pkg::pair_balanced(32'(lo_i), 32'(hi_i), 32'(tol_i));
    oob_now = calmon_pkg::over_half(32'(other_i), 32'(len_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o       <= '0;
      hi_o       <= '0;
      balanced_o <= 1'b0;
      oob_o      <= 1'b0;
      gain_o     <= 1'b0;
      refused_o  <= 1'b0;
      cleared_o  <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= fire_i;
      if (fire_i) begin
        lo_o       <= lo_i;
        hi_o       <= hi_i;
        balanced_o <= bal_now;
        oob_o      <= oob_now;
        gain_o     <= gain_i;
        refused_o  <= refused_i;
        if (gain_i == calmon_pkg::MODE_OFFSET) cleared_o <= bal_now;
      end
    end
  end
endmodule

// File: rtl/adc_xition_monitor.sv
module adc_xition_monitor #(
  parameter int CODE_W = 12,
  parameter int WIN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [CODE_W-1:0] smp_code_i,
  input  logic              gain_req_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [WIN_W-1:0]  tol_i,
  output logic [WIN_W-1:0]  lo_count_o,
  output logic [WIN_W-1:0]  hi_count_o,
  output logic              balanced_o,
  output logic              out_of_band_o,
  output logic              gain_mode_o,
  output logic              gain_refused_o,
  output logic              offset_cleared_o,
  output logic              done_o
);
  localparam int NUM_CNT = 3; // lower hits, upper hits, other codes

  logic             win_first;
  logic             win_last;
  logic             win_gain;
  logic             win_refused;
  logic [WIN_W-1:0] win_len;
  logic             win_mid;
  logic [WIN_W-1:0] win_idx;
  logic [WIN_W-1:0] win_len_held;
  logic             window_fire;
  logic [NUM_CNT-1:0] hit;
  logic [WIN_W-1:0] cnt_next [NUM_CNT];

  calmon_window #(.WIN_W(WIN_W)) i_window (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .valid_i        (smp_valid_i),
    .gain_req_i     (gain_req_i),
    .gain_allowed_i (offset_cleared_o),
    .len_req_i      (win_len_i),
    .first_o        (win_first),
    .last_o         (win_last),
    .gain_eff_o     (win_gain),
    .refused_o      (win_refused),
    .len_eff_o      (win_len),
    .mid_o          (win_mid),
    .idx_o          (win_idx),
    .len_held_o     (win_len_held)
  );

  calmon_classify #(.CODE_W(CODE_W)) i_classify (
    .valid_i     (smp_valid_i),
    .code_i      (smp_code_i),
    .gain_i      (win_gain),
    .hit_lo_o    (hit[0]),
    .hit_hi_o    (hit[1]),
    .hit_other_o (hit[2])
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    calmon_counter #(.W(WIN_W)) i_counter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (smp_valid_i),
      .restart_i (win_first),
      .inc_i     (hit[g]),
      .next_o    (cnt_next[g])
    );
  end

  assign window_fire = win_last;

  calmon_judge #(.WIN_W(WIN_W)) i_judge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (window_fire),
    .lo_i       (cnt_next[0]),
    .hi_i       (cnt_next[1]),
    .other_i    (cnt_next[2]),
    .len_i      (win_len),
    .tol_i      (tol_i),
    .gain_i     (win_gain),
    .refused_i  (win_refused),
    .lo_o       (lo_count_o),
    .hi_o       (hi_count_o),
    .balanced_o (balanced_o),
    .oob_o      (out_of_band_o),
    .gain_o     (gain_mode_o),
    .refused_o  (gain_refused_o),
    .cleared_o  (offset_cleared_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/adc_xition_monitor_chk.sv
module adc_xition_monitor_chk #(
  parameter int WIN_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic [WIN_W-1:0] lo_count_o,
  input logic [WIN_W-1:0] hi_count_o,
  input logic             balanced_o,
  input logic             gain_mode_o,
  input logic             gain_refused_o,
  input logic             offset_cleared_o,
  input logic             done_o,
  input logic             win_mid,
  input logic [WIN_W-1:0] win_idx,
  input logic [WIN_W-1:0] win_len_held
);
  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(smp_valid_i)); // R3
  AST_LO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(lo_count_o)); // R3
  AST_HI_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(hi_count_o)); // R3
  AST_BAL_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    balanced_o |-> (lo_count_o != '0) && (hi_count_o != '0)); // R4
  AST_GAIN_AFTER_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && gain_mode_o) |-> $past(offset_cleared_o)); // R6
  AST_REFUSED_IS_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_refused_o |-> !gain_mode_o); // R6
  AST_CLEAR_KEPT_BY_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && gain_mode_o) |-> $stable(offset_cleared_o)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_mid |-> (win_idx < win_len_held)); // R2
endmodule

bind adc_xition_monitor adc_xition_monitor_chk #(.WIN_W(WIN_W)) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .smp_valid_i      (smp_valid_i),
  .lo_count_o       (lo_count_o),
  .hi_count_o       (hi_count_o),
  .balanced_o       (balanced_o),
  .gain_mode_o      (gain_mode_o),
  .gain_refused_o   (gain_refused_o),
  .offset_cleared_o (offset_cleared_o),
  .done_o           (done_o),
  .win_mid          (win_mid),
  .win_idx          (win_idx),
  .win_len_held     (win_len_held)
);

// File: tb/test_adc_xition_monitor.sv
module test_adc_xition_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 12;
  localparam int WIN_W  = 12;

  typedef struct {
    int lo;
    int hi;
    bit bal;
    bit oob;
    bit gain;
    bit refused;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic              gain_req = 1'b0;
  logic [WIN_W-1:0]  win_len = '0;
  logic [WIN_W-1:0]  tol = '0;
  logic [WIN_W-1:0]  lo_cnt;
  logic [WIN_W-1:0]  hi_cnt;
  logic              bal;
  logic              oob;
  logic              gmode;
  logic              refused;
  logic              cleared;
  logic              done;

  int   n_checks = 0;
  int   n_fail = 0;
  int   n_done = 0;
  int   n_pushed = 0;
  bit   model_cleared = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_xition_monitor #(.CODE_W(CODE_W), .WIN_W(WIN_W)) i_adc_xition_monitor (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_code_i(code),
    .gain_req_i(gain_req), .win_len_i(win_len), .tol_i(tol),
    .lo_count_o(lo_cnt), .hi_count_o(hi_cnt), .balanced_o(bal),
    .out_of_band_o(oob), .gain_mode_o(gmode), .gain_refused_o(refused),
    .offset_cleared_o(cleared), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: predicts the window result, then plays its samples
  task automatic run_window(input bit g, input int len_set, input int tl,
                            input int n000, input int n001, input int nfe,
                            input int nff, input int noth, input int gap);
    exp_t e;
    int   rem [5];
    int   total;
    int   len_eff;
    int   other;
    int   sent;
    bit   eg;
    logic [CODE_W-1:0] codes [5];
    codes[0] = 12'h000; codes[1] = 12'h001; codes[2] = 12'hFFE;
    codes[3] = 12'hFFF; codes[4] = 12'h800;
    rem[0] = n000; rem[1] = n001; rem[2] = nfe; rem[3] = nff; rem[4] = noth;
    total   = n000 + n001 + nfe + nff + noth;
    len_eff = (len_set == 0) ? 1 : len_set;
    eg        = g && model_cleared;
    e.gain    = eg;
    e.refused = g && !model_cleared;
    e.lo      = eg ? nfe : n000;
    e.hi      = eg ? nff : n001;
    other     = total - e.lo - e.hi;
    e.bal     = (e.lo > 0) && (e.hi > 0) &&
                (((e.lo > e.hi) ? e.lo - e.hi : e.hi - e.lo) <= tl);
    e.oob     = other > (len_eff / 2);
    if (!eg) model_cleared = e.bal;
    sb.push_back(e);
    n_pushed++;
    sent = 0;
    while (sent < total) begin
      for (int k = 0; k < 5; k++) begin
        if (rem[k] > 0) begin
          @(negedge clk);
          valid = 1'b1;
          code  = codes[k];
          tol   = WIN_W'(tl);
          if (sent == 0) begin
            gain_req = g;
            win_len  = WIN_W'(len_set);
          end else begin
            gain_req = !g;            // R8: mid-window changes ignored
            win_len  = WIN_W'(3);
          end
          rem[k]--;
          sent++;
          if (gap > 0 && (sent % gap) == 0 && sent < total) begin
            @(negedge clk);
            valid = 1'b0;             // R10: idle cycle with a target code on the bus
            code  = 12'h000;
          end
        end
      end
    end
    @(negedge clk);
    valid = 1'b0;
    code  = 12'h001;
  endtask

  // monitor: pops and compares on every done pulse
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      n_done++;
      if (sb.size() == 0) begin
        chk("R3 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R1 lo_count", int'(lo_cnt), e.lo);
        chk("R1 hi_count", int'(hi_cnt), e.hi);
        chk("R4 balanced", int'(bal), int'(e.bal));
        chk("R5 out_of_band", int'(oob), int'(e.oob));
        chk("R6 gain_mode", int'(gmode), int'(e.gain));
        chk("R6 gain_refused", int'(refused), int'(e.refused));
        chk("R7 offset_cleared", int'(cleared), int'(model_cleared_at_pop()));
      end
    end
  end

  // offset_cleared after the window being popped: replayed from the queue order
  bit cleared_trace[$];
  function automatic bit model_cleared_at_pop();
    if (cleared_trace.size() == 0) return 1'b0;
    return cleared_trace.pop_front();
  endfunction

  task automatic win(input bit g, input int len_set, input int tl,
                     input int n000, input int n001, input int nfe,
                     input int nff, input int noth, input int gap);
    fork
      run_window(g, len_set, tl, n000, n001, nfe, nff, noth, gap);
    join_none
    #0;
    cleared_trace.push_back(model_cleared);
    wait fork;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9 lo_count reset", int'(lo_cnt), 0);
    chk("R9 hi_count reset", int'(hi_cnt), 0);
    chk("R9 flags reset", int'({bal, oob, gmode, refused, cleared, done}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10: idle cycles before any sample make no done
    chk("R10 no done while idle", int'(done), 0);

    win(1, 6, 0, 0, 0, 3, 3, 0, 0);       // R6 refused before offset trim
    win(0, 10, 0, 5, 5, 0, 0, 0, 3);      // R4 balanced offset, gaps
    win(1, 8, 0, 0, 0, 4, 4, 0, 0);       // R1 gain codes
    win(1, 9, 2, 0, 0, 6, 3, 0, 0);       // R4 diff 3 > tol 2
    win(1, 9, 3, 0, 0, 6, 3, 0, 2);       // R4 diff 3 == tol 3
    win(0, 6, 10, 6, 0, 0, 0, 0, 0);      // R4 zero count; R7 cleared drops
    win(1, 4, 0, 0, 0, 2, 2, 0, 0);       // R6 refused again
    win(0, 8, 0, 2, 2, 0, 0, 4, 0);       // R5 others == half: no flag
    win(0, 8, 1, 2, 1, 0, 0, 5, 0);       // R5 others > half
    win(0, 0, 0, 1, 0, 0, 0, 0, 0);       // R2 length 0 acts as 1
    win(0, 1024, 0, 512, 512, 0, 0, 0, 7);// R2 long window
    win(1, 5, 1, 2, 0, 2, 1, 0, 0);       // R1 offset codes count as other in gain

    repeat (4) @(negedge clk);
    chk("R3 one done per window", n_done, n_pushed);
    chk("R2 scoreboard drained", sb.size(), 0);
    chk("R7 final offset_cleared", int'(cleared), int'(model_cleared));
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule